// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block takes the 3-byte check code recomputed over a 256-byte data chunk and the 3-byte check code fetched from storage alongside it, and decides what kind of damage, if any, the chunk has suffered. It forms a 24-bit syndrome from the two codes and counts the ones in it. Depending on that count, it reports one of four outcomes: clean, a single flipped data bit that can be repaired, damage confined to the stored code bytes, or damage beyond repair. For a repairable error it also gives the byte offset within the chunk and the bit within that byte.

The result is registered and appears one clock after the start strobe, with a one-cycle done pulse. It then holds until the next strobe. A read-modify port lets the surrounding datapath stream chunk bytes past the block while the result is held. With repair enabled, the byte whose index matches the faulty byte comes out with the bad bit inverted, and every other byte passes through untouched.

Both codes are packed with code byte 0 in bits 7:0, code byte 1 in bits 15:8 and code byte 2 in bits 23:16.

Top module: `ecc_syndrome_fixer`

## Requirements
- R1: The syndrome is calc_code XOR read_code; when it is zero the strobe yields status 0 (clean).
- R2: A start strobe sampled on a rising edge updates status, err_byte and err_bit at that edge and raises done for exactly that one following cycle. Without a strobe, done is low and the three results keep their values.
- R3: A syndrome with exactly 11 ones yields status 1 (repairable), whatever pattern those ones form.
- R4: The 11-bit error address is gathered from odd syndrome bits, least significant first: bits 3, 5, 7, then bits 17, 19, 21, 23, then bits 9, 11, 13, 15. err_bit is address bits 2:0 and err_byte is address bits 10:3. Both read zero whenever status is not 1.
- R5: A syndrome with exactly one 1 yields status 2 (code-area error).
- R6: Any other nonzero count of ones (2 to 10, or 12 to 24) yields status 3 (unrepairable).
- R7: When fix_en is high, status is 1 and rmw_index equals err_byte, fixed_data is rmw_data with bit err_bit inverted.
- R8: In every other case, fixed_data equals rmw_data. This covers fix_en low, an index mismatch, and status 0, 2 or 3.
- R9: After reset, status, err_byte, err_bit and done are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Evaluate the two codes on this edge |
| calc_code | input | 24 | Code recomputed over the chunk |
| read_code | input | 24 | Code fetched from storage |
| fix_en | input | 1 | Enable repair on the read-modify port |
| rmw_index | input | 8 | Offset of the byte presented on rmw_data |
| rmw_data | input | 8 | Chunk byte to pass or repair |
| status | output | 2 | 0 clean, 1 repairable, 2 code-area error, 3 unrepairable |
| err_byte | output | 8 | Faulty byte offset (status 1 only) |
| err_bit | output | 3 | Faulty bit within that byte (status 1 only) |
| done | output | 1 | One-cycle pulse when a result is loaded |
| fixed_data | output | 8 | rmw_data, repaired when it is the faulty byte |

## Verification
The syndromes chosen cover several distinct cases, which separate counting from pattern matching:
- equal codes, non-zero in both operands;
- proper single-bit signatures for addresses 0, 0x7FF and an interior address;
- a lone one at each end of the word;
- counts of 2, 10, 12 and 24 ones;
- an 11-one syndrome that is not a valid signature.

The 11-one non-signature case shows that classification rests on the count alone, and its odd bits still decode to an address. Repair is tried at the matching index, a neighbouring index, with repair disabled, and after a code-area error whose zero err_byte would otherwise collide with index 0.

// File: rtl/ecc_syndrome_fixer.sv
module ecc_syndrome_fixer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] calc_code,
  input  logic [23:0] read_code,
  input  logic        fix_en,
  input  logic [7:0]  rmw_index,
  input  logic [7:0]  rmw_data,
  output logic [1:0]  status,
  output logic [7:0]  err_byte,
  output logic [2:0]  err_bit,
  output logic        done,
  output logic [7:0]  fixed_data
);

  localparam logic [1:0] ST_OK   = 2'd0;
  localparam logic [1:0] ST_FIX  = 2'd1;
  localparam logic [1:0] ST_CODE = 2'd2;
  localparam logic [1:0] ST_BAD  = 2'd3;

  logic [23:0] syn;
  logic [4:0]  ones;
  logic [10:0] addr;
  logic [1:0]  cls;

  assign syn  = calc_code ^ read_code;
  assign ones = 5'($countones(syn));
  assign addr = {syn[15], syn[13], syn[11], syn[9],
                 syn[23], syn[21], syn[19], syn[17],
                 syn[7],  syn[5],  syn[3]};

  always_comb begin
    if (ones == 5'd0)       cls = ST_OK;
    else if (ones == 5'd11) cls = ST_FIX;
    else if (ones == 5'd1)  cls = ST_CODE;
    else                    cls = ST_BAD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status   <= ST_OK;
      err_byte <= '0;
      err_bit  <= '0;
      done     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        status   <= cls;
        err_byte <= (cls == ST_FIX) ? addr[10:3] : 8'd0;
        err_bit  <= (cls == ST_FIX) ? addr[2:0]  : 3'd0;
      end
    end
  end

  logic hit;
  assign hit        = fix_en && (status == ST_FIX) && (rmw_index == err_byte);
  assign fixed_data = hit ? (rmw_data ^ (8'd1 << err_bit)) : rmw_data;

endmodule

// File: rtl/ecc_syndrome_fixer_chk.sv
module ecc_syndrome_fixer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [23:0] calc_code,
  input logic [23:0] read_code,
  input logic        fix_en,
  input logic [7:0]  rmw_index,
  input logic [7:0]  rmw_data,
  input logic [1:0]  status,
  input logic [7:0]  err_byte,
  input logic [2:0]  err_bit,
  input logic        done,
  input logic [7:0]  fixed_data
);

  p_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && calc_code == read_code) |=> status == 2'd0);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(status) && $stable(err_byte) && $stable(err_bit)));

  p_eleven_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $countones(calc_code ^ read_code) == 11) |=> status == 2'd1);

  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'd1 |-> (err_byte == 8'd0 && err_bit == 3'd0));

  p_code_area_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && $countones(calc_code ^ read_code) == 1) |=> status == 2'd2);

  p_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_en && status == 2'd1 && rmw_index == err_byte)
      |-> (fixed_data ^ rmw_data) == (8'd1 << err_bit));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fix_en || status != 2'd1 || rmw_index != err_byte) |-> fixed_data == rmw_data);

endmodule

bind ecc_syndrome_fixer ecc_syndrome_fixer_chk u_chk (.*);

// File: tb/sim_ecc_syndrome_fixer.sv
`timescale 1ns/1ps
module sim_ecc_syndrome_fixer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] calc_code = '0;
  logic [23:0] read_code = '0;
  logic        fix_en = 1'b0;
  logic [7:0]  rmw_index = '0;
  logic [7:0]  rmw_data = '0;
  logic [1:0]  status;
  logic [7:0]  err_byte;
  logic [2:0]  err_bit;
  logic        done;
  logic [7:0]  fixed_data;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ecc_syndrome_fixer u0 (.*);

  // {calc, read, status, byte, bit}
  localparam int NV = 11;
  localparam logic [60:0] VEC [NV] = '{
    {24'hA5C3E1, 24'hA5C3E1, 2'd0, 8'h00, 3'd0},  // R1 clean
    {24'h555554, 24'h000000, 2'd1, 8'h00, 3'd0},  // R3 R4 address 0
    {24'hAAAAA8, 24'h000000, 2'd1, 8'hFF, 3'd7},  // R3 R4 address 0x7FF
    {24'h8B523E, 24'h123456, 2'd1, 8'h5A, 3'd3},  // R3 R4 interior
    {24'h0007FF, 24'h000000, 2'd1, 8'h10, 3'd7},  // R3 count only
    {24'h000001, 24'h000000, 2'd2, 8'h00, 3'd0},  // R5 low end
    {24'h000000, 24'h800000, 2'd2, 8'h00, 3'd0},  // R5 high end
    {24'h000003, 24'h000000, 2'd3, 8'h00, 3'd0},  // R6 two ones
    {24'h555550, 24'h000000, 2'd3, 8'h00, 3'd0},  // R6 ten ones
    {24'h555555, 24'h000000, 2'd3, 8'h00, 3'd0},  // R6 twelve ones
    {24'hFFFFFF, 24'h000000, 2'd3, 8'h00, 3'd0}   // R6 all ones
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [23:0] c, logic [23:0] r);
    @(negedge clk);
    calc_code = c; read_code = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 status", 32'(status), 0);
    check("R9 done", 32'(done), 0);
    check("R9 err_byte", 32'(err_byte), 0);
    check("R9 err_bit", 32'(err_bit), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      strobe(VEC[i][60:37], VEC[i][36:13]);
      check("R2 done pulse", 32'(done), 1);
      check("R1 R3 R5 R6 status", 32'(status), 32'(VEC[i][12:11]));
      check("R4 err_byte", 32'(err_byte), 32'(VEC[i][10:3]));
      check("R4 err_bit", 32'(err_bit), 32'(VEC[i][2:0]));
    end

    // R2: hold without strobe
    strobe(24'h8B523E, 24'h123456);
    calc_code = 24'h000003; read_code = 24'h0;
    @(negedge clk);
    check("R2 done low", 32'(done), 0);
    check("R2 hold status", 32'(status), 1);
    check("R2 hold err_byte", 32'(err_byte), 32'h5A);

    // R7: repair at matching index
    fix_en = 1'b1; rmw_index = 8'h5A; rmw_data = 8'hF0;
    #1 check("R7 flip", 32'(fixed_data), 32'hF8);
    rmw_index = 8'h5B;
    #1 check("R8 index mismatch", 32'(fixed_data), 32'hF0);
    fix_en = 1'b0; rmw_index = 8'h5A;
    #1 check("R8 fix disabled", 32'(fixed_data), 32'hF0);

    // R7: bit 7 at byte 0xFF
    strobe(24'hAAAAA8, 24'h0);
    fix_en = 1'b1; rmw_index = 8'hFF; rmw_data = 8'h81;
    #1 check("R7 flip bit7", 32'(fixed_data), 32'h01);

    // R8: code-area error leaves byte 0 alone
    strobe(24'h000001, 24'h0);
    rmw_index = 8'h00; rmw_data = 8'h3C;
    #1 check("R8 code-area passthrough", 32'(fixed_data), 32'h3C);
    strobe(24'hFFFFFF, 24'h0);
    #1 check("R8 unrepairable passthrough", 32'(fixed_data), 32'h3C);

    // R9: reset mid-run
    strobe(24'h555554, 24'h0);
    rst_n = 1'b0;
    #1 check("R9 status after reset", 32'(status), 0);
    check("R9 fixed passthrough", 32'(fixed_data), 32'h3C);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule